// File: doc/BRIEF.md
# Host Bus Style Auto-Detector

This block sits at the edge of an 8-bit peripheral and connects a microcontroller bus to the peripheral's register file without glue logic. After a hardware reset it does not yet know how the host signals its accesses. It watches the bus to find out two things. The first is whether the two control pins carry separate active-low read and write strobes, or a direction level plus a data strobe. The second is whether the low address arrives on the data bus under an address latch strobe (multiplexed) or on dedicated address pins (non-multiplexed).

Both choices start at a default: split strobes and a multiplexed bus. The first write the host performs settles the control style. A write to an odd address followed by a chip-selected read from an odd address selects the non-multiplexed bus. The first chip-selected read freezes both choices until the next reset. The block synchronizes all host pins to its clock. It hands the register file one-cycle read and write pulses, the decoded low address and the write data, and it reports the frozen configuration on three status outputs.

Top module: `hbus_autodetect`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, cfg_style, cfg_bus_sep, cfg_locked, reg_rd_stb and reg_wr_stb are all 0. cfg_style 0 means split strobes. cfg_bus_sep 0 means multiplexed.
- R2: While unlocked and undecided, if pin B goes low and pin A then goes low before pin B returns high, cfg_style becomes 1 (direction on pin B, 0 = write; data strobe on pin A). If pin B returns high while pin A stayed high, cfg_style stays 0. Chip select is not needed.
- R3: Once the first write has fixed cfg_style, later writes of the other pattern do not change it.
- R4: The first cycle with chip select low, pin A low and pin B high sets cfg_locked to 1. If no write came first, the result is cfg_style 0 and cfg_bus_sep 0.
- R5: cfg_bus_sep becomes 1 only if A0 was high during some write (pin B low) before the locking read, and A0 is high during that locking read. Otherwise it stays 0.
- R6: While cfg_locked is 1, no host activity changes cfg_style, cfg_bus_sep or cfg_locked.
- R7: Each chip-selected read gives exactly one reg_rd_stb pulse of one cycle. reg_addr then holds the low address of that read.
- R8: Each chip-selected write gives exactly one reg_wr_stb pulse of one cycle, after the write ends. reg_addr holds its address and reg_wdata holds the data seen last while the write was active.
- R9: With cfg_bus_sep 0 the address is the low ADDR_W bits of host_data, taken at the falling edge of host_ale, and host_addr is ignored. With cfg_bus_sep 1 the address is host_addr.
- R10: A reset after lock returns the block to the R1 defaults and reopens detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| host_cs_n | input | 1 | Chip select, active low |
| host_ctl_a_n | input | 1 | Pin A: read strobe (split style) or data strobe (direction style), active low |
| host_ctl_b | input | 1 | Pin B: write strobe, active low (split style), or direction, 1 = read (direction style) |
| host_addr | input | ADDR_W | Dedicated low address pins; bit 0 is A0 |
| host_ale | input | 1 | Address latch strobe for the multiplexed bus |
| host_data | input | DATA_W | Host data bus (address too when multiplexed) |
| reg_rd_stb | output | 1 | One-cycle read pulse to the register file |
| reg_wr_stb | output | 1 | One-cycle write pulse to the register file |
| reg_addr | output | ADDR_W | Low address of the current access |
| reg_wdata | output | DATA_W | Write data of the last write |
| cfg_style | output | 1 | Control style: 0 split strobes, 1 direction plus data strobe |
| cfg_bus_sep | output | 1 | Bus mode: 0 multiplexed, 1 non-multiplexed |
| cfg_locked | output | 1 | Configuration frozen until reset |

## Verification
Random sessions reset the block and then act as one of four hosts: split or direction signalling, on a multiplexed or a separate bus. Each session makes a detection write and a locking read, and then runs a stream of random reads and writes. In multiplexed sessions the address pins carry junk after lock, which shows whether the address really comes from the latch. Directed cases separate the detection rules from each other. A read with no write before it tests the defaults. A write of one pattern followed by the other tests the first-write-wins rule. An odd write with an even read, and an even write with an odd read, must both stay multiplexed. An odd write and read after lock must change nothing.

// File: rtl/hbad_pkg.sv
package hbad_pkg;
  typedef enum logic { STYLE_SPLIT = 1'b0, STYLE_DIRSTB = 1'b1 } style_e;
  typedef enum logic { BUS_MUX = 1'b0, BUS_SEP = 1'b1 } bus_mode_e;
endpackage

// File: rtl/hbad_sync.sv
module hbad_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= INIT;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hbad_detect.sv
module hbad_detect
  import hbad_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cs_n,
  input  logic      ctl_a_n,
  input  logic      ctl_b,
  input  logic      a0,
  output style_e    style,
  output bus_mode_e mode,
  output logic      locked
);
  logic style_done;
  logic odd_wr_seen;
  logic b_prev;
  logic wr_phase;
  logic rd_final;

  // pin B low marks a write in either style
  assign wr_phase = !ctl_b;
  // a read looks the same in both styles
  assign rd_final = !cs_n && !ctl_a_n && ctl_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      style       <= STYLE_SPLIT;
      mode        <= BUS_MUX;
      locked      <= 1'b0;
      style_done  <= 1'b0;
      odd_wr_seen <= 1'b0;
      b_prev      <= 1'b1;
    end else begin
      b_prev <= ctl_b;
      if (!locked) begin
        if (!style_done) begin
          if (wr_phase && !ctl_a_n) begin
            style      <= STYLE_DIRSTB;
            style_done <= 1'b1;
          end else if (!b_prev && ctl_b) begin
            style      <= STYLE_SPLIT;
            style_done <= 1'b1;
          end
        end
        if (wr_phase && a0) odd_wr_seen <= 1'b1;
        if (rd_final) begin
          locked     <= 1'b1;
          style_done <= 1'b1;
          mode       <= (odd_wr_seen && a0) ? BUS_SEP : BUS_MUX;
        end
      end
    end
  end
endmodule

// File: rtl/hbad_strobe.sv
module hbad_strobe
  import hbad_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              ctl_a_n,
  input  logic              ctl_b,
  input  logic              ale,
  input  logic [ADDR_W-1:0] addr_pins,
  input  logic [DATA_W-1:0] data_pins,
  input  style_e            style,
  input  bus_mode_e         mode,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);
  logic              rd_act, wr_act, rd_act_q, wr_act_q, ale_q;
  logic [ADDR_W-1:0] mux_addr, cur_addr, wr_addr;
  logic [DATA_W-1:0] wr_data;

  always_comb begin
    cur_addr = (mode == BUS_SEP) ? addr_pins : mux_addr;
    rd_act   = !cs_n && !ctl_a_n && ctl_b;
    if (style == STYLE_SPLIT) wr_act = !cs_n && !ctl_b;
    else                      wr_act = !cs_n && !ctl_a_n && !ctl_b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_act_q <= 1'b0;
      wr_act_q <= 1'b0;
      ale_q    <= 1'b0;
      rd_stb   <= 1'b0;
      wr_stb   <= 1'b0;
      mux_addr <= '0;
      wr_addr  <= '0;
      wr_data  <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else begin
      rd_act_q <= rd_act;
      wr_act_q <= wr_act;
      ale_q    <= ale;
      rd_stb   <= rd_act && !rd_act_q;
      wr_stb   <= wr_act_q && !wr_act;
      if (ale_q && !ale) mux_addr <= data_pins[ADDR_W-1:0];
      if (wr_act && !wr_act_q) wr_addr <= cur_addr;
      if (wr_act) wr_data <= data_pins;
      if (rd_act && !rd_act_q) begin
        addr_q <= cur_addr;
      end else if (wr_act_q && !wr_act) begin
        addr_q  <= wr_addr;
        wdata_q <= wr_data;
      end
    end
  end
endmodule

// File: rtl/hbus_autodetect.sv
module hbus_autodetect
  import hbad_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_cs_n,
  input  logic              host_ctl_a_n,
  input  logic              host_ctl_b,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_ale,
  input  logic [DATA_W-1:0] host_data,
  output logic              reg_rd_stb,
  output logic              reg_wr_stb,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              cfg_style,
  output logic              cfg_bus_sep,
  output logic              cfg_locked
);
  localparam int SW = 4 + ADDR_W + DATA_W;
  localparam logic [SW-1:0] IDLE = {{(SW-3){1'b0}}, 3'b111};

  logic [SW-1:0] raw, synced, delayed;
  style_e        style;
  bus_mode_e     mode;

  assign raw = {host_ale, host_data, host_addr, host_ctl_b, host_ctl_a_n, host_cs_n};

  hbad_sync #(.W(SW), .STAGES(SYNC_STAGES), .INIT(IDLE)) sync_i (
    .clk(clk), .rst(rst), .d(raw), .q(synced)
  );

  // one extra stage so the strobe logic sees a configuration change in step
  always_ff @(posedge clk) begin
    if (rst) delayed <= IDLE;
    else     delayed <= synced;
  end

  hbad_detect detect_i (
    .clk(clk), .rst(rst),
    .cs_n(synced[0]), .ctl_a_n(synced[1]), .ctl_b(synced[2]), .a0(synced[3]),
    .style(style), .mode(mode), .locked(cfg_locked)
  );

  hbad_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) strobe_i (
    .clk(clk), .rst(rst),
    .cs_n(delayed[0]), .ctl_a_n(delayed[1]), .ctl_b(delayed[2]),
    .ale(delayed[SW-1]),
    .addr_pins(delayed[3 +: ADDR_W]),
    .data_pins(delayed[3+ADDR_W +: DATA_W]),
    .style(style), .mode(mode),
    .rd_stb(reg_rd_stb), .wr_stb(reg_wr_stb),
    .addr_q(reg_addr), .wdata_q(reg_wdata)
  );

  assign cfg_style   = (style == STYLE_DIRSTB);
  assign cfg_bus_sep = (mode == BUS_SEP);
endmodule

// File: rtl/hbad_checker.sv
module hbad_checker (
  input logic clk,
  input logic rst,
  input logic rd_stb,
  input logic wr_stb,
  input logic style,
  input logic bus_sep,
  input logic locked
);
  p_reset_defaults_r1: assert property (@(posedge clk)
    rst |=> (!locked && !bus_sep && !style && !rd_stb && !wr_stb));

  p_style_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    style |=> style);

  p_sep_only_locked_r5: assert property (@(posedge clk) disable iff (rst)
    bus_sep |-> locked);

  p_locked_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    locked |=> (locked && $stable(style) && $stable(bus_sep)));

  p_rd_single_r7: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> !rd_stb);

  p_wr_single_r8: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  p_excl_strobes_r8: assert property (@(posedge clk) disable iff (rst)
    !(rd_stb && wr_stb));
endmodule

bind hbus_autodetect hbad_checker chk_i (
  .clk(clk), .rst(rst), .rd_stb(reg_rd_stb), .wr_stb(reg_wr_stb),
  .style(cfg_style), .bus_sep(cfg_bus_sep), .locked(cfg_locked)
);

// File: tb/hbus_autodetect_tb_top.sv
module hbus_autodetect_tb_top;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int H = 4;
  localparam int GAP = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, a_n = 1'b1, b = 1'b1, ale = 1'b0;
  logic [AW-1:0] apins = '0;
  logic [DW-1:0] dbus = '0;
  logic rd_stb, wr_stb, style, sep, locked;
  logic [AW-1:0] raddr;
  logic [DW-1:0] rwdata;

  int checks = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [AW-1:0] last_addr;
  logic [DW-1:0] last_data;
  bit done = 0;

  always #10 clk = ~clk;

  hbus_autodetect #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .host_cs_n(cs_n), .host_ctl_a_n(a_n), .host_ctl_b(b),
    .host_addr(apins), .host_ale(ale), .host_data(dbus),
    .reg_rd_stb(rd_stb), .reg_wr_stb(wr_stb), .reg_addr(raddr), .reg_wdata(rwdata),
    .cfg_style(style), .cfg_bus_sep(sep), .cfg_locked(locked)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (rd_stb) begin rd_cnt++; last_addr = raddr; end
      if (wr_stb) begin wr_cnt++; last_addr = raddr; last_data = rwdata; end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cs_n = 1'b1; a_n = 1'b1; b = 1'b1; ale = 1'b0; apins = '0; dbus = '0;
    wait_n(3);
    rst = 1'b0;
  endtask

  task automatic addr_phase(input bit mux, input logic [AW-1:0] adr, input logic [AW-1:0] junk);
    if (mux) begin
      apins = junk;
      dbus = {{(DW-AW){1'b0}}, adr};
      ale = 1'b1; wait_n(H);
      ale = 1'b0; wait_n(H);
    end else begin
      apins = adr;
    end
  endtask

  task automatic host_write(input bit dirstb, input bit mux, input bit sel,
                            input logic [AW-1:0] adr, input logic [DW-1:0] dat,
                            input logic [AW-1:0] junk);
    @(negedge clk);
    addr_phase(mux, adr, junk);
    dbus = dat; cs_n = !sel; b = 1'b0;
    if (dirstb) begin
      wait_n(H); a_n = 1'b0; wait_n(H); a_n = 1'b1; wait_n(H);
    end else begin
      wait_n(2*H);
    end
    b = 1'b1; wait_n(H);
    cs_n = 1'b1; wait_n(GAP);
  endtask

  task automatic host_read(input bit mux, input bit sel, input logic [AW-1:0] adr,
                           input logic [AW-1:0] junk);
    @(negedge clk);
    addr_phase(mux, adr, junk);
    cs_n = !sel; b = 1'b1; wait_n(1);
    a_n = 1'b0; wait_n(2*H);
    a_n = 1'b1; wait_n(H);
    cs_n = 1'b1; wait_n(GAP);
  endtask

  function automatic bit exp_sep(input bit odd_write_seen, input bit a0_at_lock);
    return odd_write_seen && a0_at_lock;
  endfunction

  task automatic check_cfg(input string req, input bit e_lock, input bit e_style, input bit e_sep);
    chk(locked == e_lock, req, "cfg_locked", locked, e_lock);
    chk(style == e_style, req, "cfg_style", style, e_style);
    chk(sep == e_sep, req, "cfg_bus_sep", sep, e_sep);
  endtask

  task automatic check_wr(input string req, input int c0, input bit ck_addr,
                          input logic [AW-1:0] ea, input logic [DW-1:0] ed);
    chk(wr_cnt == c0 + 1, req, "write pulse count", wr_cnt - c0, 1);
    if (ck_addr) chk(last_addr == ea, req, "write address", last_addr, ea);
    chk(last_data == ed, req, "write data", last_data, ed);
  endtask

  task automatic check_rd(input string req, input int c0, input logic [AW-1:0] ea);
    chk(rd_cnt == c0 + 1, req, "read pulse count", rd_cnt - c0, 1);
    chk(last_addr == ea, req, "read address", last_addr, ea);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int c0;
    logic [AW-1:0] wa, ra, junk;
    logic [DW-1:0] wd;
    void'($urandom(32'h5EED));

    // R1: outputs during and just after reset
    wait_n(2);
    chk(!rd_stb && !wr_stb, "R1", "strobes in reset", {rd_stb, wr_stb}, 0);
    check_cfg("R1", 0, 0, 0);
    rst = 1'b0; wait_n(1);
    check_cfg("R1", 0, 0, 0);

    // R4: a read with no write first locks the defaults
    c0 = rd_cnt;
    host_read(1, 1, 4'h6, 4'h0);
    check_cfg("R4", 1, 0, 0);
    check_rd("R7", c0, 4'h6);

    // R10: reset after lock reopens detection
    do_reset(); wait_n(1);
    check_cfg("R10", 0, 0, 0);

    // R2 / R3: direction-style write first, then a split-style write
    host_write(1, 1, 0, 4'h1, 8'h11, 4'h0);
    check_cfg("R2", 0, 1, 0);
    host_write(0, 1, 0, 4'h2, 8'h22, 4'h0);
    check_cfg("R3", 0, 1, 0);
    host_read(1, 1, 4'h2, 4'h0);
    check_cfg("R3", 1, 1, 0);

    // R2 / R3: split-style write first, then a direction-style write
    do_reset();
    host_write(0, 1, 0, 4'h3, 8'h33, 4'h0);
    check_cfg("R2", 0, 0, 0);
    host_write(1, 1, 0, 4'h4, 8'h44, 4'h0);
    check_cfg("R3", 0, 0, 0);

    // R5: odd write then even read stays multiplexed
    do_reset();
    host_write(0, 0, 0, 4'h5, 8'h55, 4'h0);
    host_read(0, 1, 4'h4, 4'h0);
    check_cfg("R5", 1, 0, exp_sep(1, 0));
    // R6: odd write and odd read after lock change nothing
    host_write(1, 0, 0, 4'h7, 8'h77, 4'h0);
    host_read(0, 1, 4'h7, 4'h0);
    check_cfg("R6", 1, 0, 0);

    // R5: even write then odd read stays multiplexed
    do_reset();
    host_write(0, 0, 0, 4'h6, 8'h66, 4'h0);
    host_read(0, 1, 4'h9, 4'h0);
    check_cfg("R5", 1, 0, exp_sep(0, 1));

    // R5: odd write then odd read selects the separate bus
    do_reset();
    host_write(0, 0, 0, 4'hB, 8'hBB, 4'h0);
    c0 = rd_cnt;
    host_read(0, 1, 4'hD, 4'h0);
    check_cfg("R5", 1, 0, exp_sep(1, 1));
    check_rd("R9", c0, 4'hD);

    // random sessions: style and bus mode chosen per session
    for (int s = 0; s < 16; s++) begin
      bit dirstb, bsep;
      dirstb = 1'($urandom_range(0, 1));
      bsep = 1'($urandom_range(0, 1));
      do_reset();
      wa = AW'($urandom); ra = AW'($urandom); wd = DW'($urandom);
      if (bsep) begin wa[0] = 1'b1; ra[0] = 1'b1; end
      c0 = wr_cnt;
      host_write(dirstb, !bsep, 1, wa, wd, 4'h0);
      check_wr("R8", c0, !bsep, wa, wd);
      chk(style == dirstb, "R2", "detected style", style, dirstb);
      c0 = rd_cnt;
      host_read(!bsep, 1, ra, 4'h0);
      check_cfg("R5", 1, dirstb, exp_sep(bsep, bsep));
      check_rd("R7", c0, ra);
      for (int k = 0; k < 8; k++) begin
        bit is_wr;
        is_wr = 1'($urandom_range(0, 1));
        wa = AW'($urandom); wd = DW'($urandom); junk = AW'($urandom);
        if (is_wr) begin
          c0 = wr_cnt;
          host_write(dirstb, !bsep, 1, wa, wd, junk);
          check_wr("R9", c0, 1, wa, wd);
        end else begin
          c0 = rd_cnt;
          host_read(!bsep, 1, wa, junk);
          check_rd("R9", c0, wa);
        end
      end
      check_cfg("R6", 1, dirstb, bsep);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule